// File: doc/BRIEF.md
# Successive-Approximation Step Sequencer

This block is the digital half of a 10-bit charge-redistribution converter. Once the analog front end has held its sample, a single-cycle start pulse launches a binary search. The search resolves one weight per clock, beginning with the heaviest weight (512) and ending with weight 1. On each step the block drives a trial-weight vector to the capacitor array and reads a single comparator bit back.

The trial vector holds every weight already accepted, plus the weight under test. A weight that is accepted stays asserted until the conversion ends. A rejected weight drops back to the low reference on the next step. After the last step the accepted weights are copied into a result register, and `done_o` pulses for one cycle.

An abort input cancels a conversion that is in flight. It returns the sequencer to idle and leaves the previous result in place.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `trial_o` and `result_o` are all zero.
- R2: A `start_i` pulse seen in idle (with `abort_i` low) sets `busy_o` on the next cycle. On that cycle `trial_o` is 10'h200, meaning only bit 9 is set.
- R3: While busy, one bit is tried per cycle, from bit 9 down to bit 0. During the step for bit k, `trial_o` equals the weights accepted at positions above k, with bit k also set.
- R4: `cmp_above_i` = 1 during the step for bit k means the node is above the trip point. Bit k is then rejected: it is 0 in the result and clear in `trial_o` from the next step on.
- R5: `cmp_above_i` = 0 during the step for bit k accepts that bit. It is 1 in the result and stays set in `trial_o` for every later step of the conversion.
- R6: `done_o` is high for exactly one cycle. That cycle is the tenth clock edge after the edge that accepted `start_i`. In the same cycle `result_o` shows the new code and `busy_o` is low.
- R7: With an ideal comparator, the result equals the input code. An input at or above full scale gives 1023, and an input of 0 gives 0.
- R8: `abort_i` high while busy returns the block to idle on the next edge, with `trial_o` at zero. No `done_o` follows, and `result_o` keeps the previous code.
- R9: A `start_i` pulse that arrives while busy is ignored. The running conversion completes on its original schedule, and only one `done_o` pulse occurs.
- R10: `result_o` changes only on a `done_o` cycle and holds its value between conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion (sample is held) |
| abort_i | input | 1 | Cancel the conversion in progress |
| cmp_above_i | input | 1 | Comparator: summing node above trip point |
| trial_o | output | 10 | Weights switched to the upper reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Last completed conversion code |

## Verification
`busy_o` and the first trial vector are due one edge after start is accepted. The trial vector then moves on once per edge, and `done_o` with the new code lands on the tenth edge. After an abort, the return to idle is due on the very next edge. The bench drives inputs and samples outputs on falling edges, so each of these results is read exactly half a cycle after the rising edge that produced it. A driver task pushes each expected code into a queue. A monitor pops the queue on every `done_o` and flags any pulse that arrives with nothing expected, which catches extra pulses after aborts or ignored starts.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
  parameter int WIDTH = 10,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          launch_o,
  output logic          step_en_o,
  output logic          load_o,
  output logic [IW-1:0] idx_o
);
  import sar_pkg::*;

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic          done_q;

  assign busy_o    = (phase_q == PH_RUN);
  assign launch_o  = !busy_o && start_i && !abort_i;
  assign step_en_o = busy_o && !abort_i;
  assign load_o    = step_en_o && (idx_q == '0);
  assign idx_o     = idx_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= load_o;
      if (busy_o) begin
        if (abort_i || idx_q == '0) phase_q <= PH_IDLE;
        else                        idx_q   <= idx_q - 1'b1;
      end else if (launch_o) begin
        phase_q <= PH_RUN;
        idx_q   <= IW'(WIDTH - 1);
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && abort_i) |=> (!busy_o && !done_o));
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !abort_i && idx_q != '0) |=> (busy_o && idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 10,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             step_en_i,
  input  logic             busy_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] code_nxt_o
);
  logic [WIDTH-1:0] kept_q;
  logic [WIDTH-1:0] kept_nxt;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic hit;
    assign hit         = (idx_i == IW'(b));
    assign kept_nxt[b] = (step_en_i && hit) ? !cmp_above_i : kept_q[b];
    assign trial_o[b]  = busy_i && (kept_q[b] || hit);
  end

  assign code_nxt_o = kept_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        kept_q <= '0;
    else if (launch_i)  kept_q <= '0;
    else if (step_en_i) kept_q <= kept_nxt;
  end

  assert_idle_trial_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (trial_o == '0));
  assert_one_new_weight_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ($countones(trial_o & ~kept_q) <= 1));
  assert_kept_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(step_en_i)) |-> ((kept_q & $past(kept_q)) == $past(kept_q)));
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int WIDTH = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] code_i,
  input  logic             done_i,
  output logic [WIDTH-1:0] result_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_o <= '0;
    else if (load_i) result_o <= code_i;
  end

  assert_result_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_o));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 10,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  logic          launch, step_en, load;
  logic [IW-1:0] idx;
  logic [WIDTH-1:0] code_nxt;

  sar_step_ctrl #(.WIDTH(WIDTH)) u_step (
    .clk_i, .rst_ni, .start_i, .abort_i,
    .busy_o, .done_o,
    .launch_o(launch), .step_en_o(step_en), .load_o(load), .idx_o(idx)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk_i, .rst_ni,
    .launch_i(launch), .step_en_i(step_en), .busy_i(busy_o), .idx_i(idx),
    .cmp_above_i, .trial_o, .code_nxt_o(code_nxt)
  );

  sar_result_reg #(.WIDTH(WIDTH)) u_res (
    .clk_i, .rst_ni, .load_i(load), .code_i(code_nxt), .done_i(done_o), .result_o
  );

  assert_first_trial_msb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !abort_i) |=> (busy_o && trial_o == WIDTH'(1) << (WIDTH - 1)));
endmodule

// File: tb/tb_sar_ctrl.sv
module tb_sar_ctrl;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort_in = 1'b0;
  logic [W:0] vin = '0;
  logic cmp_above;
  logic [W-1:0] trial, result;
  logic busy, done;
  int checks = 0, fails = 0;
  int exp_q[$];
  int last_code = 0;

  always #4 clk = ~clk;

  assign cmp_above = ({1'b0, trial} > vin);

  sar_ctrl #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort_in),
    .cmp_above_i(cmp_above), .trial_o(trial), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected code on every done pulse (R6, R7, R10)
  initial forever begin
    @(negedge clk);
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R9 unexpected done", 1, 0);
      else chk("R7 result", int'(result), exp_q.pop_front());
    end
  end

  task automatic convert(input int v, input bit dup);
    int code;
    code = (v > 1023) ? 1023 : v;
    vin = (W+1)'(v);
    exp_q.push_back(code);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = W - 1; k >= 0; k--) begin
      int exp_t;
      exp_t = (code & ~((1 << (k + 1)) - 1)) | (1 << k);
      chk("R2 busy", int'(busy), 1);
      chk((k == W - 1) ? "R2 first trial" : "R3/R4/R5 trial", int'(trial), exp_t & 1023);
      start = (dup && k == 5);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R6 done", int'(done), 1);
    chk("R6 busy low", int'(busy), 0);
    chk("R6 result", int'(result), code);
    @(negedge clk);
    chk("R6 pulse width", int'(done), 0);
    chk("R9 idle", int'(busy), 0);
    last_code = code;
  endtask

  task automatic aborted(input int v);
    vin = (W+1)'(v);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (3) @(negedge clk);
    abort_in = 1'b1;
    @(negedge clk) abort_in = 1'b0;
    chk("R8 busy", int'(busy), 0);
    chk("R8 trial", int'(trial), 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R8 no done", int'(done), 0);
    end
    chk("R8 result kept", int'(result), last_code);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 trial", int'(trial), 0);
    chk("R1 result", int'(result), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    convert(300, 1'b0);
    convert(0, 1'b0);        // R7 zero
    convert(1500, 1'b0);     // R7 above full scale
    convert(1023, 1'b0);
    convert(512, 1'b0);
    convert(511, 1'b0);
    convert(341, 1'b1);      // R9 start while busy
    aborted(700);            // R8
    convert(682, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 hold", int'(result), last_code);
    end
    chk("R6 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule